// File: doc/BRIEF.md
# Wormhole Router Input Port Controller

This block is one input port of a five-port mesh router that uses wormhole switching. Flits arrive from the neighbouring router with a request strobe and begin-of-packet and end-of-packet marks. A receive-side link state machine admits them into a small flit FIFO. A credit level sent back upstream tells the sender whether the FIFO has room. The link starts a packet only on a head flit. It returns to its idle state after the tail, so the next packet can be taken in while the previous one is still draining.

On the send side, an output state machine moves flits from the FIFO into a single output register. It presents a flit toward the crossbar only while the output port of its packet is granted, and it transfers the flit when the downstream credit is present. The grant bit seen when the head leaves is latched as the packet's route. Body and tail flits follow only while that same bit stays granted. When a tail flit leaves, a one-cycle end-of-packet notice tells the routing function to release the route. Route computation, arbitration and the crossbar are outside this block.

Top module: `wh_input_port`

## Requirements
- R1: During reset `up_credit_o` is 1, and `dn_valid_o` and `rf_eop_o` are 0.
- R2: From idle, the link admits a flit only when `up_req_i`, `up_bop_i` and `up_credit_o` are all 1. A flit offered while idle with `up_bop_i`=0 is discarded and never appears downstream.
- R3: Every admitted flit appears downstream exactly once and in admission order, with its data and its marks intact. `dn_bop_o` is 1 only on the first flit of a packet, and `dn_eop_o` is copied from the upstream mark.
- R4: `up_credit_o` is 0 exactly when the FIFO holds DEPTH flits, and a request made while it is 0 is ignored. With the downstream side blocked, exactly DEPTH+1 flits are admitted: DEPTH in the FIFO and one in the output register.
- R5: A head flit is presented (`dn_valid_o`=1) only while at least one bit of `gnt_i` is set.
- R6: After a head flit transfers, the remaining flits of that packet are presented only while the `gnt_i` bit that was set at the head transfer is still set. Any other grant pattern stalls them.
- R7: While `dn_credit_i` is 0, a presented flit stays unchanged on `dn_data_o`/`dn_bop_o`/`dn_eop_o` until it transfers. A flit transfers in a cycle where `dn_valid_o` and `dn_credit_i` are both 1.
- R8: `rf_eop_o` is 1 in exactly the cycles in which a flit with `dn_eop_o`=1 transfers.
- R9: After a tail flit the link accepts the next packet's head at once, even when no flit of the earlier packet has been forwarded.
- R10: A single-flit packet (begin and end marks both 1) transfers with one `rf_eop_o` pulse. The next head may then leave on a different grant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_req_i | input | 1 | Upstream flit strobe |
| up_bop_i | input | 1 | Upstream flit is a packet head |
| up_eop_i | input | 1 | Upstream flit is a packet tail |
| up_data_i | input | DATA_W | Upstream flit payload |
| up_credit_o | output | 1 | Credit level to the sender, 1 when the FIFO has room |
| gnt_i | input | N_OUT | Grant vector, one bit per reachable output port |
| dn_credit_i | input | 1 | Downstream credit level, 1 when a flit may leave |
| dn_valid_o | output | 1 | A flit is presented to the crossbar |
| dn_bop_o | output | 1 | Presented flit is a packet head |
| dn_eop_o | output | 1 | Presented flit is a packet tail |
| dn_data_o | output | DATA_W | Presented flit payload |
| rf_eop_o | output | 1 | Tail has left, release the route |

## Verification
Wrong link state shows up at the next upstream flit. A stray flit is then stored, or a real head is dropped, and the downstream flit order goes wrong as soon as that flit reaches the output register. A wrong FIFO pointer or count shows as a repeated, missing or reordered flit at `dn_data_o`, or as a credit level that disagrees with the number of flits admitted while the downstream side is blocked. A stale route or packet state in the output machine shows in the same cycle as a body flit presented on the wrong grant bit, a head held back despite a grant, or an `rf_eop_o` pulse out of step with the tail transfer.

// File: rtl/wh_port_pkg.sv
package wh_port_pkg;
  localparam int unsigned FLAG_W = 2;  // flit = {bop, eop, data}

  typedef enum logic {
    LINK_IDLE,
    LINK_RECV
  } link_state_e;

  typedef enum logic {
    OUT_HEAD,
    OUT_BODY
  } out_state_e;
endpackage

// File: rtl/wh_link_rx.sv
module wh_link_rx
  import wh_port_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned FLIT_W = DATA_W + FLAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              bop_i,
  input  logic              eop_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              space_i,
  output logic              wr_en_o,
  output logic [FLIT_W-1:0] wr_flit_o
);
  link_state_e state_q, state_d;

  always_comb begin
    wr_en_o = req_i && space_i && ((state_q == LINK_RECV) || bop_i);
    state_d = state_q;
    if (wr_en_o) state_d = eop_i ? LINK_IDLE : LINK_RECV;
    // head mark normalised to the link state
    wr_flit_o = {(state_q == LINK_IDLE), eop_i, data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LINK_IDLE;
    else         state_q <= state_d;
  end

  AST_LINK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LINK_RECV && $past(state_q) == LINK_IDLE) |-> $past(req_i && bop_i && space_i)); // R2
endmodule

// File: rtl/wh_flit_fifo.sv
module wh_flit_fifo #(
  parameter int unsigned WIDTH = 18,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full_o    = (cnt_q == CW'(DEPTH));
  assign empty_o   = (cnt_q == '0);
  assign rd_data_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (rd_en_i) rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({wr_en_i, rd_en_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !full_o); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !empty_o); // R3
endmodule

// File: rtl/wh_out_ctrl.sv
module wh_out_ctrl
  import wh_port_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_OUT  = 4,
  localparam int unsigned FLIT_W = DATA_W + FLAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  logic [FLIT_W-1:0] fifo_flit_i,
  output logic              pop_o,
  input  logic [N_OUT-1:0]  gnt_i,
  input  logic              dn_credit_i,
  output logic              dn_valid_o,
  output logic              dn_bop_o,
  output logic              dn_eop_o,
  output logic [DATA_W-1:0] dn_data_o,
  output logic              rf_eop_o
);
  out_state_e        state_q;
  logic              out_vld_q;
  logic [FLIT_W-1:0] out_flit_q;
  logic [N_OUT-1:0]  route_q;
  logic              gnt_ok, xfer;

  always_comb begin
    gnt_ok     = (state_q == OUT_HEAD) ? (|gnt_i) : (|(gnt_i & route_q));
    dn_valid_o = out_vld_q && gnt_ok;
    xfer       = dn_valid_o && dn_credit_i;
    pop_o      = !fifo_empty_i && (!out_vld_q || xfer);
    dn_bop_o   = out_flit_q[FLIT_W-1];
    dn_eop_o   = out_flit_q[FLIT_W-2];
    dn_data_o  = out_flit_q[DATA_W-1:0];
    rf_eop_o   = xfer && out_flit_q[FLIT_W-2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q  <= 1'b0;
      out_flit_q <= '0;
    end else if (pop_o) begin
      out_vld_q  <= 1'b1;
      out_flit_q <= fifo_flit_i;
    end else if (xfer) begin
      out_vld_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= OUT_HEAD;
      route_q <= '0;
    end else if (xfer) begin
      if (state_q == OUT_HEAD) route_q <= gnt_i;
      state_q <= out_flit_q[FLIT_W-2] ? OUT_HEAD : OUT_BODY;
    end
  end

  AST_HOLD_FLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_q && !xfer) |=> (out_vld_q && $stable(out_flit_q))); // R7
  AST_ROUTE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == OUT_BODY) |=> (state_q == OUT_HEAD) || $stable(route_q)); // R6
  AST_EOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_eop_o |=> (state_q == OUT_HEAD)); // R8
endmodule

// File: rtl/wh_input_port.sv
module wh_input_port
  import wh_port_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned N_OUT  = 4,
  localparam int unsigned FLIT_W = DATA_W + FLAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_req_i,
  input  logic              up_bop_i,
  input  logic              up_eop_i,
  input  logic [DATA_W-1:0] up_data_i,
  output logic              up_credit_o,
  input  logic [N_OUT-1:0]  gnt_i,
  input  logic              dn_credit_i,
  output logic              dn_valid_o,
  output logic              dn_bop_o,
  output logic              dn_eop_o,
  output logic [DATA_W-1:0] dn_data_o,
  output logic              rf_eop_o
);
  logic              wr_en, rd_en, full, empty;
  logic [FLIT_W-1:0] wr_flit, rd_flit;

  assign up_credit_o = !full;

  wh_link_rx #(.DATA_W(DATA_W)) u_link (
    .clk_i, .rst_ni,
    .req_i(up_req_i), .bop_i(up_bop_i), .eop_i(up_eop_i), .data_i(up_data_i),
    .space_i(up_credit_o), .wr_en_o(wr_en), .wr_flit_o(wr_flit)
  );

  wh_flit_fifo #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_data_i(wr_flit),
    .rd_en_i(rd_en), .rd_data_o(rd_flit),
    .full_o(full), .empty_o(empty)
  );

  wh_out_ctrl #(.DATA_W(DATA_W), .N_OUT(N_OUT)) u_out (
    .clk_i, .rst_ni,
    .fifo_empty_i(empty), .fifo_flit_i(rd_flit), .pop_o(rd_en),
    .gnt_i, .dn_credit_i,
    .dn_valid_o, .dn_bop_o, .dn_eop_o, .dn_data_o, .rf_eop_o
  );

  AST_CREDIT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(up_credit_o) |-> $past(wr_en && !rd_en)); // R4
endmodule

// File: tb/wh_input_port_bench.sv
module wh_input_port_bench;
  localparam int DW = 16, DEPTH = 4, NO = 4, FW = DW + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst_ni, up_req_i, up_bop_i, up_eop_i, up_credit_o;
  logic [DW-1:0] up_data_i, dn_data_o;
  logic [NO-1:0] gnt_i;
  logic          dn_credit_i, dn_valid_o, dn_bop_o, dn_eop_o, rf_eop_o;

  wh_input_port #(.DATA_W(DW), .DEPTH(DEPTH), .N_OUT(NO)) u_wh_input_port (
    .clk_i(clk), .rst_ni, .up_req_i, .up_bop_i, .up_eop_i, .up_data_i, .up_credit_o,
    .gnt_i, .dn_credit_i, .dn_valid_o, .dn_bop_o, .dn_eop_o, .dn_data_o, .rf_eop_o
  );

  int chk_cnt = 0, fail_cnt = 0;
  logic [FW-1:0] exp_q[$];
  bit lk_in_pkt = 0, out_in_pkt = 0, prev_hold = 0, stray_now = 0, stray_cur = 0;
  bit gen_hold = 1, cred_fix = 0;
  logic [NO-1:0] route = '0, gnt_fix = '0;
  logic [FW-1:0] prev_flit = '0;
  logic [DW-1:0] data_ctr = 16'h0100;
  int acc_cnt = 0, xfer_cnt = 0, eop_cnt = 0;
  int pkt_len = 0, pkt_idx = 0, len_fix = 0, req_pct = 100, dn_mode = 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive();
    int r;
    stray_cur = 0;
    if (pkt_idx == pkt_len && !gen_hold) begin
      pkt_len = (len_fix != 0) ? len_fix : 1 + int'($urandom % 5);
      pkt_idx = 0;
    end
    if (stray_now || (dn_mode == 0 && !lk_in_pkt && pkt_idx == 0 && ($urandom % 12) == 0)) begin
      up_req_i = 1; up_bop_i = 0; up_eop_i = 0; up_data_i = 16'hBAD0;
      stray_cur = 1; stray_now = 0;
    end else if (pkt_idx < pkt_len) begin
      up_req_i  = (int'($urandom % 100) < req_pct);
      up_bop_i  = (pkt_idx == 0);
      up_eop_i  = (pkt_idx == pkt_len - 1);
      up_data_i = data_ctr;
    end else begin
      up_req_i = 0;
    end
    if (dn_mode == 0) begin
      dn_credit_i = ($urandom % 10) < 6;
      r = int'($urandom % 10);
      if (out_in_pkt && r < 6) gnt_i = route;
      else if (r < 8)          gnt_i = NO'(1 << ($urandom % NO));
      else                     gnt_i = '0;
    end else if (dn_mode == 2) begin
      dn_credit_i = 1;
      gnt_i = out_in_pkt ? route : NO'(1);
    end else begin
      dn_credit_i = cred_fix;
      gnt_i = gnt_fix;
    end
  endtask

  task automatic eval();
    bit acc, xfer, legal;
    logic [FW-1:0] got, fr;
    acc   = up_req_i && up_credit_o && (lk_in_pkt || up_bop_i);
    got   = {dn_bop_o, dn_eop_o, dn_data_o};
    xfer  = dn_valid_o && dn_credit_i;
    legal = out_in_pkt ? |(gnt_i & route) : |gnt_i;
    if (dn_valid_o) begin
      if (exp_q.size() == 0) check(0, "R3", "flit with none pending", got, 0);
      else begin
        fr = exp_q[0];
        check(got == fr, "R3", "flit order/content", got, fr);
      end
      if (!out_in_pkt) check(|gnt_i, "R5", "head shown without grant", gnt_i, 1);
      else check(|(gnt_i & route), "R6", "body shown off route", gnt_i, route);
      if (prev_hold) check(got == prev_flit, "R7", "held flit changed", got, prev_flit);
    end else if (prev_hold && legal) begin
      check(0, "R7", "held flit withdrawn under grant", 0, 1);
    end
    check(rf_eop_o == (xfer && got[FW-2]), "R8", "route release pulse", rf_eop_o, xfer && got[FW-2]);
    if (xfer) begin
      if (exp_q.size() != 0) void'(exp_q.pop_front());
      xfer_cnt++;
      if (got[FW-2]) begin eop_cnt++; out_in_pkt = 0; end
      else begin
        if (!out_in_pkt) route = gnt_i;
        out_in_pkt = 1;
      end
    end
    prev_hold = dn_valid_o && !dn_credit_i;
    prev_flit = got;
    if (acc) begin
      exp_q.push_back({!lk_in_pkt, up_eop_i, up_data_i});
      lk_in_pkt = !up_eop_i;
      acc_cnt++;
      if (!stray_cur) begin pkt_idx++; data_ctr++; end
    end
  endtask

  task automatic run_cycle();
    @(negedge clk);
    drive();
    #1;
    eval();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
  endtask

  initial begin
    #(8 * 200000);
    chk_cnt++; fail_cnt++;
    $display("FAIL R3 watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int x0, e0;
    void'($urandom(32'd7));
    rst_ni = 0; up_req_i = 0; up_bop_i = 0; up_eop_i = 0; up_data_i = '0;
    gnt_i = '0; dn_credit_i = 0;
    repeat (3) @(negedge clk);
    #1;
    check(up_credit_o == 1, "R1", "credit in reset", up_credit_o, 1);
    check(dn_valid_o == 0, "R1", "valid in reset", dn_valid_o, 0);
    check(rf_eop_o == 0, "R1", "eop notice in reset", rf_eop_o, 0);
    @(negedge clk);
    rst_ni = 1;

    // R4 / R9: downstream blocked, back-to-back 2-flit packets
    len_fix = 2; gen_hold = 0; gnt_fix = '0; cred_fix = 1; acc_cnt = 0;
    repeat (12) run_cycle();
    check(acc_cnt == DEPTH + 1, "R4", "flits admitted while blocked", acc_cnt, DEPTH + 1);
    check(up_credit_o == 0, "R4", "credit when full", up_credit_o, 0);
    check(dn_valid_o == 0, "R5", "valid without grant", dn_valid_o, 0);
    check(xfer_cnt == 0 && acc_cnt >= 3, "R9", "next head taken before forwarding", acc_cnt, DEPTH + 1);
    gen_hold = 1; gnt_fix = 4'b0010;
    repeat (30) run_cycle();
    check(exp_q.size() == 0, "R3", "drain after blocking", exp_q.size(), 0);
    check(eop_cnt == 3, "R8", "tail notices", eop_cnt, 3);

    // R2: stray non-head flit while idle
    x0 = xfer_cnt;
    stray_now = 1;
    run_cycle();
    pkt_len = 1; pkt_idx = 0;
    repeat (10) run_cycle();
    check(xfer_cnt - x0 == 1, "R2", "stray flit discarded", xfer_cnt - x0, 1);
    check(exp_q.size() == 0, "R2", "pending after stray", exp_q.size(), 0);

    // R6: grant moves to another port mid packet
    pkt_len = 3; pkt_idx = 0; gnt_fix = 4'b0001;
    for (int i = 0; i < 20 && !out_in_pkt; i++) run_cycle();
    check(out_in_pkt == 1, "R6", "head left on grant", out_in_pkt, 1);
    gnt_fix = 4'b0100;
    repeat (6) begin
      run_cycle();
      check(dn_valid_o == 0, "R6", "body stalled off route", dn_valid_o, 0);
    end
    gnt_fix = 4'b0001;
    repeat (10) run_cycle();
    check(exp_q.size() == 0, "R6", "body drained on route", exp_q.size(), 0);

    // R7 / R10: single-flit packet held, then released
    e0 = eop_cnt;
    pkt_len = 1; pkt_idx = 0; gnt_fix = 4'b1000; cred_fix = 0;
    repeat (4) run_cycle();
    check(dn_valid_o == 1, "R7", "flit held under grant", dn_valid_o, 1);
    check(eop_cnt == e0, "R7", "no transfer without credit", eop_cnt, e0);
    cred_fix = 1;
    repeat (3) run_cycle();
    check(eop_cnt - e0 == 1, "R10", "single flit tail notice", eop_cnt - e0, 1);
    check(dn_valid_o == 0 && exp_q.size() == 0, "R10", "single flit gone", dn_valid_o, 0);
    pkt_len = 1; pkt_idx = 0; gnt_fix = 4'b0001;
    repeat (5) run_cycle();
    check(eop_cnt - e0 == 2, "R10", "next head on other port", eop_cnt - e0, 2);

    // random traffic
    dn_mode = 0; gen_hold = 0; len_fix = 0; req_pct = 70;
    repeat (4000) run_cycle();

    // drain
    gen_hold = 1; dn_mode = 2;
    repeat (80) run_cycle();
    check(exp_q.size() == 0, "R3", "all admitted flits delivered", exp_q.size(), 0);
    check(up_credit_o == 1, "R4", "credit after drain", up_credit_o, 1);

    summary();
    $finish;
  end
endmodule